// File: doc/BRIEF.md
# Age-Ordered Line Fill Scheduler

This block coordinates a small pool of line fill buffers that sit in front of an in-order, pipelined memory bus. Each buffer fetches one cache line as a run of beats. The fetch starts at the beat that holds its start address, climbs upward and wraps around inside the line. The block keeps a square age matrix over the buffers. It always issues bus requests on behalf of the oldest buffer that still has beats to ask for. Because the bus answers in order, each returning beat is credited to the oldest buffer that still has responses owed to it.

Downstream logic pulls beats out one at a time. Output comes only from the oldest live buffer that still has beats to deliver, and only once the beat it is waiting on has arrived or is known to be bad. A redirect (flush) marks every busy buffer as stale. Stale buffers still soak up the responses they are owed but deliver nothing. The redirect also sets the line for the next allocation. Allocations made without a redirect chain on to the line after the previous buffer's line.

Top module: `line_fill_sched`

## Requirements
- R1: Once reset is released, `bus_req_o`, `out_valid_o` and `out_sel_o` are zero and `alloc_ready_o` is one.
- R2: Bus requests and delivered beats serve buffers strictly in allocation order, whatever slot each buffer occupies. Among busy buffers, exactly one of any pair is older, and no buffer is older than itself.
- R3: A buffer whose start beat index is b (address bits [3:2], with 4-byte beats and 4 beats per line) requests beats b, b+1, … modulo 4, exactly 4 requests per buffer. `bus_addr_o` equals the line base plus beat index times 4.
- R4: An allocation without a flush in the same cycle targets the line directly after the line of the previous allocation, starting at beat 0.
- R5: Once `bus_req_o` is high without `bus_gnt_i` or `bus_squash_i`, it stays high in the next cycle with an unchanged `bus_addr_o`.
- R6: Beats are delivered only after they have been received, in the same wrapped order in which they were requested, with `out_sel_o` one-hot for the delivering buffer. The count of granted but unanswered requests equals the sum of each buffer's requested minus received beats.
- R7: A response with `bus_err_i` high makes that beat come out with `out_err_o` = 1. That buffer then delivers nothing more, and the next delivered beat comes from the next younger buffer.
- R8: `bus_squash_i` while `bus_req_o` is high cancels that request and stops the buffer from requesting more. The cancelled beat is later delivered with `out_err_o` = 1.
- R9: On `flush_i`, every busy buffer turns stale. A request already being held is still completed, stale buffers absorb their responses and deliver nothing, and an allocation in the same cycle starts at `flush_beat_addr_i`.
- R10: `alloc_ready_o` is low while every buffer is busy, and `alloc_i` has no effect then. A buffer frees once all of its requested beats have returned and it is either stale or done delivering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_i | input | 1 | Start a new line fill |
| alloc_ready_o | output | 1 | A free buffer exists |
| flush_i | input | 1 | Redirect: stale all busy buffers, load the next address |
| flush_beat_addr_i | input | ADDR_W-2 | Redirect target as a beat address (byte address divided by 4) |
| bus_req_o | output | 1 | Bus request |
| bus_addr_o | output | ADDR_W | Byte address of the requested beat |
| bus_gnt_i | input | 1 | Request accepted |
| bus_squash_i | input | 1 | Request refused by protection check |
| bus_rvalid_i | input | 1 | In-order response beat |
| bus_err_i | input | 1 | Response beat is in error |
| out_ready_i | input | 1 | Consumer takes the offered beat |
| out_valid_o | output | 1 | A beat is offered |
| out_sel_o | output | NUM_BUF | One-hot buffer being read |
| out_addr_o | output | ADDR_W | Byte address of the offered beat |
| out_err_o | output | 1 | Offered beat is in error |

## Verification
The hardest situation to reach is a redirect that lands while the oldest buffer holds an ungranted request and earlier grants are still unanswered. The stale buffer must finish its held request and take all of those late responses before any beat for the new line is delivered. The bench gets there by allocating two lines, granting only three requests with responses withheld, then issuing a redirect to a mid-line address with an allocation in the same cycle before the bus is released. The long random phase mixes grant, response and consume delays, so buffers free out of slot order and get reused.

// File: rtl/lfs_pkg.sv
package lfs_pkg;
  localparam int unsigned DEF_NUM_BUF    = 4;
  localparam int unsigned DEF_ADDR_W     = 32;
  localparam int unsigned DEF_BEAT_BYTES = 4;
  localparam int unsigned DEF_LINE_BEATS = 4;
endpackage

// File: rtl/lfs_pick.sv
// Selects the oldest candidate: the one with no older candidate in its age row.
module lfs_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0]        cand,
  input  logic [N-1:0][N-1:0] older,
  output logic [N-1:0]        sel,
  output logic                any
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      sel[i] = cand[i] & ~|(older[i] & cand);
    end
  end
  assign any = |cand;
endmodule

// File: rtl/lfs_age.sv
// Age matrix: row i bit j set means buffer j is older than buffer i.
module lfs_age #(
  parameter int unsigned N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        alloc_vec,
  input  logic [N-1:0]        free_vec,
  input  logic [N-1:0]        busy_vec,
  output logic [N-1:0][N-1:0] older_o
);
  logic [N-1:0][N-1:0] older_q, older_d;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      if (alloc_vec[i]) begin
        older_d[i] = busy_vec & ~free_vec;
      end else if (free_vec[i]) begin
        older_d[i] = '0;
      end else begin
        older_d[i] = older_q[i] & ~free_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      older_q <= '0;
    end else begin
      older_q <= older_d;
    end
  end

  assign older_o = older_q;

  for (genvar i = 0; i < N; i++) begin : g_row
    AST_AGE_IRREFL: assert property (@(posedge clk) disable iff (!rst_n)
      !older_q[i][i]); // R2
    for (genvar j = 0; j < N; j++) begin : g_col
      AST_AGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec[i] && older_q[i][j]) |-> busy_vec[j]); // R2
      if (j < i) begin : g_pair
        AST_AGE_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
          (busy_vec[i] && busy_vec[j]) |-> (older_q[i][j] != older_q[j][i])); // R2
      end
    end
  end
endmodule

// File: rtl/lfs_slot.sv
// One line fill buffer: counters for requested, received and delivered beats,
// per-beat error bits, stale and squash state. LINE_BEATS must be a power of two.
module lfs_slot #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned BEAT_BYTES = 4,
  parameter int unsigned LINE_BEATS = 4,
  localparam int unsigned OFS = $clog2(BEAT_BYTES),
  localparam int unsigned BW  = $clog2(LINE_BEATS),
  localparam int unsigned CW  = BW + 1,
  localparam int unsigned BAW = ADDR_W - OFS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic [BAW-1:0]    alloc_addr,
  input  logic              flush,
  input  logic              req_win,
  input  logic              gnt,
  input  logic              squash,
  input  logic              rsp_win,
  input  logic              rsp_err,
  input  logic              out_win,
  output logic              busy_o,
  output logic              req_want_o,
  output logic              rsp_want_o,
  output logic              out_want_o,
  output logic              out_avail_o,
  output logic              out_err_o,
  output logic              free_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [CW-1:0]     pend_o
);
  localparam logic [CW-1:0] FULL = CW'(LINE_BEATS);

  logic                  busy_q, busy_d, stale_q, stale_d, hold_q, hold_d;
  logic                  sq_q, sq_d, eout_q, eout_d;
  logic [BAW-BW-1:0]     base_q, base_d;
  logic [BW-1:0]         first_q, first_d;
  logic [CW-1:0]         ext_q, ext_d, rvd_q, rvd_d, out_q, out_d;
  logic [LINE_BEATS-1:0] err_q, err_d;
  logic [BW-1:0]         ext_off, rvd_off, out_off;
  logic                  ext_fin, out_fin;

  assign ext_off = first_q + ext_q[BW-1:0];
  assign rvd_off = first_q + rvd_q[BW-1:0];
  assign out_off = first_q + out_q[BW-1:0];

  assign ext_fin = (ext_q == FULL) | sq_q | (stale_q & ~hold_q);
  assign out_fin = (out_q == FULL) | eout_q;

  assign busy_o      = busy_q;
  assign req_want_o  = busy_q & ~ext_fin;
  assign rsp_want_o  = busy_q & (rvd_q != ext_q);
  assign out_want_o  = busy_q & ~stale_q & ~out_fin;
  assign out_avail_o = (out_q < rvd_q) | err_q[out_off];
  assign out_err_o   = err_q[out_off];
  assign free_o      = busy_q & ext_fin & (rvd_q == ext_q) & (stale_q | out_fin);
  assign req_addr_o  = {base_q, ext_off, {OFS{1'b0}}};
  assign out_addr_o  = {base_q, out_off, {OFS{1'b0}}};
  assign pend_o      = ext_q - rvd_q;

  always_comb begin
    busy_d  = busy_q;
    stale_d = stale_q;
    hold_d  = hold_q;
    sq_d    = sq_q;
    eout_d  = eout_q;
    base_d  = base_q;
    first_d = first_q;
    ext_d   = ext_q;
    rvd_d   = rvd_q;
    out_d   = out_q;
    err_d   = err_q;
    if (alloc_en) begin
      busy_d  = 1'b1;
      stale_d = 1'b0;
      hold_d  = 1'b0;
      sq_d    = 1'b0;
      eout_d  = 1'b0;
      base_d  = alloc_addr[BAW-1:BW];
      first_d = alloc_addr[BW-1:0];
      ext_d   = '0;
      rvd_d   = '0;
      out_d   = '0;
      err_d   = '0;
    end else begin
      if (free_o) begin
        busy_d = 1'b0;
      end
      if (flush && busy_q) begin
        stale_d = 1'b1;
      end
      if (req_win) begin
        if (squash) begin
          sq_d           = 1'b1;
          err_d[ext_off] = 1'b1;
          hold_d         = 1'b0;
        end else if (gnt) begin
          ext_d  = ext_q + CW'(1);
          hold_d = 1'b0;
        end else begin
          hold_d = 1'b1;
        end
      end
      if (rsp_win) begin
        rvd_d = rvd_q + CW'(1);
        if (rsp_err) begin
          err_d[rvd_off] = 1'b1;
        end
      end
      if (out_win) begin
        out_d = out_q + CW'(1);
        if (err_q[out_off]) begin
          eout_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stale_q <= 1'b0;
      hold_q  <= 1'b0;
      sq_q    <= 1'b0;
      eout_q  <= 1'b0;
      base_q  <= '0;
      first_q <= '0;
      ext_q   <= '0;
      rvd_q   <= '0;
      out_q   <= '0;
      err_q   <= '0;
    end else begin
      busy_q  <= busy_d;
      stale_q <= stale_d;
      hold_q  <= hold_d;
      sq_q    <= sq_d;
      eout_q  <= eout_d;
      if (alloc_en) begin
        base_q  <= base_d;
        first_q <= first_d;
      end
      ext_q <= ext_d;
      rvd_q <= rvd_d;
      out_q <= out_d;
      err_q <= err_d;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> ((ext_q <= FULL) && (rvd_q <= ext_q) && (out_q <= FULL))); // R3
  AST_NO_OVER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_win && gnt && !squash) |=> (ext_q <= FULL) && $past(ext_q < FULL)); // R3
endmodule

// File: rtl/line_fill_sched.sv
module line_fill_sched
  import lfs_pkg::*;
#(
  parameter int unsigned NUM_BUF    = DEF_NUM_BUF,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned BEAT_BYTES = DEF_BEAT_BYTES,
  parameter int unsigned LINE_BEATS = DEF_LINE_BEATS,
  localparam int unsigned OFS = $clog2(BEAT_BYTES),
  localparam int unsigned BW  = $clog2(LINE_BEATS),
  localparam int unsigned CW  = BW + 1,
  localparam int unsigned BAW = ADDR_W - OFS,
  localparam int unsigned OW  = $clog2(NUM_BUF * LINE_BEATS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_i,
  output logic               alloc_ready_o,
  input  logic               flush_i,
  input  logic [BAW-1:0]     flush_beat_addr_i,
  output logic               bus_req_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  input  logic               bus_gnt_i,
  input  logic               bus_squash_i,
  input  logic               bus_rvalid_i,
  input  logic               bus_err_i,
  input  logic               out_ready_i,
  output logic               out_valid_o,
  output logic [NUM_BUF-1:0] out_sel_o,
  output logic [ADDR_W-1:0]  out_addr_o,
  output logic               out_err_o
);
  logic [NUM_BUF-1:0]              busy, req_want, rsp_want, out_want, avail, errv, freev;
  logic [NUM_BUF-1:0]              alloc_vec, req_pick, rsp_pick, out_pick;
  logic [NUM_BUF-1:0][ADDR_W-1:0]  req_addr, out_addr;
  logic [NUM_BUF-1:0][CW-1:0]      pend;
  logic [NUM_BUF-1:0][NUM_BUF-1:0] older;
  logic                            any_free, alloc_go, req_any, rsp_any, out_any;
  logic [BAW-1:0]                  pf_q, pf_d, alloc_addr;

  // Lowest-index free slot takes the next allocation.
  always_comb begin
    alloc_vec = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        alloc_vec    = '0;
        alloc_vec[i] = 1'b1;
      end
    end
  end
  assign any_free      = ~&busy;
  assign alloc_ready_o = any_free;
  assign alloc_go      = alloc_i & any_free;
  assign alloc_addr    = flush_i ? flush_beat_addr_i : pf_q;

  // Next-allocation address: redirect target or the line after the last one.
  always_comb begin
    pf_d = pf_q;
    if (alloc_go) begin
      pf_d = {alloc_addr[BAW-1:BW] + 1'b1, {BW{1'b0}}};
    end else if (flush_i) begin
      pf_d = flush_beat_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_q <= '0;
    end else if (alloc_go || flush_i) begin
      pf_q <= pf_d;
    end
  end

  lfs_age #(.N(NUM_BUF)) u_age (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec & {NUM_BUF{alloc_go}}),
    .free_vec  (freev),
    .busy_vec  (busy),
    .older_o   (older)
  );

  lfs_pick #(.N(NUM_BUF)) u_pick_req (
    .cand (req_want), .older (older), .sel (req_pick), .any (req_any)
  );
  lfs_pick #(.N(NUM_BUF)) u_pick_rsp (
    .cand (rsp_want), .older (older), .sel (rsp_pick), .any (rsp_any)
  );
  lfs_pick #(.N(NUM_BUF)) u_pick_out (
    .cand (out_want), .older (older), .sel (out_pick), .any (out_any)
  );

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_slot
    lfs_slot #(
      .ADDR_W     (ADDR_W),
      .BEAT_BYTES (BEAT_BYTES),
      .LINE_BEATS (LINE_BEATS)
    ) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (alloc_go & alloc_vec[i]),
      .alloc_addr  (alloc_addr),
      .flush       (flush_i),
      .req_win     (req_pick[i]),
      .gnt         (bus_gnt_i),
      .squash      (bus_squash_i),
      .rsp_win     (rsp_pick[i] & bus_rvalid_i),
      .rsp_err     (bus_err_i),
      .out_win     (out_pick[i] & avail[i] & out_ready_i),
      .busy_o      (busy[i]),
      .req_want_o  (req_want[i]),
      .rsp_want_o  (rsp_want[i]),
      .out_want_o  (out_want[i]),
      .out_avail_o (avail[i]),
      .out_err_o   (errv[i]),
      .free_o      (freev[i]),
      .req_addr_o  (req_addr[i]),
      .out_addr_o  (out_addr[i]),
      .pend_o      (pend[i])
    );
  end

  always_comb begin
    bus_addr_o = '0;
    out_addr_o = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      bus_addr_o = bus_addr_o | (req_addr[i] & {ADDR_W{req_pick[i]}});
      out_addr_o = out_addr_o | (out_addr[i] & {ADDR_W{out_pick[i]}});
    end
  end

  assign bus_req_o   = req_any;
  assign out_valid_o = out_any & |(out_pick & avail);
  assign out_sel_o   = out_pick & {NUM_BUF{out_valid_o}};
  assign out_err_o   = out_valid_o & |(out_pick & errv);

  // Outstanding-request tracker used only by the consistency check below.
  logic [OW-1:0] outst_q, pend_sum;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outst_q <= '0;
    end else begin
      outst_q <= outst_q
               + OW'(bus_req_o & bus_gnt_i & ~bus_squash_i)
               - OW'(bus_rvalid_i & rsp_any);
    end
  end
  always_comb begin
    pend_sum = '0;
    for (int i = 0; i < NUM_BUF; i++) begin
      pend_sum = pend_sum + (busy[i] ? OW'(pend[i]) : OW'(0));
    end
  end

  AST_PEND_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    pend_sum == outst_q); // R6
  AST_OUT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(out_pick)); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req_o) |-> $past(bus_gnt_i | bus_squash_i)); // R5
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_req_o & ~bus_gnt_i & ~bus_squash_i) |-> (bus_req_o && $stable(bus_addr_o))); // R5
  AST_FULL_NO_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy && alloc_i) |=> $stable(busy)); // R10
endmodule

// File: tb/sim_line_fill_sched.sv
module sim_line_fill_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int NALLOC = 40;
  localparam int TOT = NALLOC * 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_i = 1'b0, flush_i = 1'b0;
  logic [29:0] flush_beat_addr_i = '0;
  logic        bus_gnt_i = 1'b0, bus_squash_i = 1'b0, bus_rvalid_i = 1'b0, bus_err_i = 1'b0;
  logic        out_ready_i = 1'b0;
  logic        alloc_ready_o, bus_req_o, out_valid_o, out_err_o;
  logic [31:0] bus_addr_o, out_addr_o;
  logic [NB-1:0] out_sel_o;

  int checks = 0, fails = 0, pending = 0, cyc = 0;
  logic [31:0] olog_a [0:63];
  logic        olog_e [0:63];
  logic [31:0] rlog   [0:63];
  int on = 0, rn = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_fill_sched u0 (
    .clk (clk), .rst_n (rst_n),
    .alloc_i (alloc_i), .alloc_ready_o (alloc_ready_o),
    .flush_i (flush_i), .flush_beat_addr_i (flush_beat_addr_i),
    .bus_req_o (bus_req_o), .bus_addr_o (bus_addr_o),
    .bus_gnt_i (bus_gnt_i), .bus_squash_i (bus_squash_i),
    .bus_rvalid_i (bus_rvalid_i), .bus_err_i (bus_err_i),
    .out_ready_i (out_ready_i), .out_valid_o (out_valid_o),
    .out_sel_o (out_sel_o), .out_addr_o (out_addr_o), .out_err_o (out_err_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Expected byte address of the m-th beat of a chain of lines that starts at s.
  function automatic logic [31:0] exp_addr(input logic [31:0] s, input int m);
    int n = m / 4;
    int k = m % 4;
    int f = (n == 0) ? int'(s[3:2]) : 0;
    return {s[31:4], 4'b0} + 32'(n * 16) + 32'(((f + k) % 4) * 4);
  endfunction

  task automatic clear_in();
    alloc_i = 1'b0; flush_i = 1'b0; bus_gnt_i = 1'b0; bus_squash_i = 1'b0;
    bus_rvalid_i = 1'b0; bus_err_i = 1'b0; out_ready_i = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
    clear_in();
  endtask

  task automatic do_op(input bit fl, input logic [31:0] a, input bit al);
    @(negedge clk);
    clear_in();
    flush_i = fl;
    flush_beat_addr_i = a[31:2];
    alloc_i = al;
  endtask

  // Bus and consumer service loop; logs granted addresses and delivered beats.
  task automatic run_svc(input int ncyc, input int err_at, input int sq_at, input bit rsp_on, input int gnt_lim);
    int evt = 0;
    int ng = 0;
    int nr = 0;
    on = 0; rn = 0;
    repeat (ncyc) begin
      @(negedge clk);
      clear_in();
      out_ready_i = 1'b1;
      if (bus_req_o) begin
        if (evt == sq_at) begin
          bus_squash_i = 1'b1; evt++;
        end else if (ng < gnt_lim) begin
          bus_gnt_i = 1'b1; ng++; evt++;
          if (rn < 64) rlog[rn] = bus_addr_o;
          rn++;
        end
      end
      if (rsp_on && pending > 0) begin
        bus_rvalid_i = 1'b1;
        bus_err_i = (nr == err_at);
        nr++;
      end
      if (out_valid_o) begin
        if (on < 64) begin olog_a[on] = out_addr_o; olog_e[on] = out_err_o; end
        on++;
      end
      pending = pending + int'(bus_gnt_i) - int'(bus_rvalid_i);
    end
    idle();
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: got %h expected %h", cyc, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(bus_req_o == 1'b0, "R1 bus_req", 32'(bus_req_o), 0);
    chk(out_valid_o == 1'b0 && out_sel_o == '0, "R1 out_valid", 32'(out_valid_o), 0);
    chk(alloc_ready_o == 1'b1, "R1 alloc_ready", 32'(alloc_ready_o), 1);

    // R7: error on second response of the first buffer
    do_op(1, 32'h2000, 1);
    do_op(0, 0, 1);
    run_svc(60, 1, -1, 1, 99);
    chk(rn == 8, "R3 request count", 32'(rn), 8);
    for (int k = 0; k < 4; k++) chk(rlog[k] == 32'h2000 + 32'(4*k), "R3 request addr", rlog[k], 32'h2000 + 32'(4*k));
    chk(on == 6, "R7 delivered count", 32'(on), 6);
    chk(olog_a[0] == 32'h2000 && !olog_e[0], "R7 first beat", olog_a[0], 32'h2000);
    chk(olog_a[1] == 32'h2004 && olog_e[1], "R7 errored beat", olog_a[1], 32'h2004);
    for (int k = 0; k < 4; k++)
      chk(olog_a[2+k] == 32'h2010 + 32'(4*k) && !olog_e[2+k], "R7 R4 next buffer", olog_a[2+k], 32'h2010 + 32'(4*k));

    // R8: squash of the second request
    do_op(1, 32'h3000, 1);
    run_svc(30, -1, 1, 1, 99);
    chk(rn == 1 && rlog[0] == 32'h3000, "R8 grants", 32'(rn), 1);
    chk(bus_req_o == 1'b0, "R8 no more requests", 32'(bus_req_o), 0);
    chk(on == 2, "R8 delivered count", 32'(on), 2);
    chk(olog_a[1] == 32'h3004 && olog_e[1], "R8 squashed beat err", olog_a[1], 32'h3004);
    chk(alloc_ready_o == 1'b1, "R10 freed after squash", 32'(alloc_ready_o), 1);

    // R9: redirect while a request is held and grants are unanswered
    do_op(1, 32'h4000, 1);
    do_op(0, 0, 1);
    run_svc(6, -1, -1, 0, 3);
    chk(on == 0, "R6 nothing before responses", 32'(on), 0);
    do_op(1, 32'h5004, 1);
    run_svc(60, -1, -1, 1, 99);
    chk(rn == 5 && rlog[0] == 32'h400c, "R9 held request completes", rlog[0], 32'h400c);
    chk(rlog[1] == 32'h5004, "R9 new start", rlog[1], 32'h5004);
    chk(on == 4, "R9 stale silent", 32'(on), 4);
    chk(olog_a[0] == 32'h5004, "R9 first beat", olog_a[0], 32'h5004);
    chk(olog_a[3] == 32'h5000, "R3 wrap", olog_a[3], 32'h5000);
    chk(pending == 0 && !bus_req_o && !out_valid_o, "R9 drained", 32'(pending), 0);

    // R10: fill every buffer, extra allocation ignored
    do_op(1, 32'h6000, 1);
    do_op(0, 0, 1);
    do_op(0, 0, 1);
    do_op(0, 0, 1);
    idle();
    chk(alloc_ready_o == 1'b0, "R10 full", 32'(alloc_ready_o), 0);
    do_op(0, 0, 1);
    run_svc(120, -1, -1, 1, 99);
    chk(on == 16, "R10 extra alloc ignored", 32'(on), 16);
    for (int k = 0; k < 16; k++)
      chk(olog_a[k] == 32'h6000 + 32'(4*k), "R2 R4 order", olog_a[k], 32'h6000 + 32'(4*k));
    chk(alloc_ready_o == 1'b1, "R10 freed", 32'(alloc_ready_o), 1);

    // Random phase: mid-line start, random grant, response and consume timing
    begin
      logic [31:0] s = 32'h0001_1008;
      int na = 0, ri = 0, oi = 0, guard = 0;
      bit prev_req = 0, prev_gnt = 0;
      logic [31:0] prev_addr = '0;
      do_op(1, s, 0);
      while (oi < TOT && guard < 6000) begin
        guard++;
        @(negedge clk);
        clear_in();
        if (prev_req && !prev_gnt)
          chk(bus_req_o && bus_addr_o == prev_addr, "R5 hold", bus_addr_o, prev_addr);
        if (alloc_ready_o && na < NALLOC && ($urandom % 3) != 0) begin
          alloc_i = 1'b1; na++;
        end
        bus_gnt_i = bus_req_o && (($urandom % 10) < 7);
        if (bus_gnt_i) begin
          chk(bus_addr_o == exp_addr(s, ri), "R3 R4 request", bus_addr_o, exp_addr(s, ri));
          ri++;
        end
        bus_rvalid_i = (pending > 0) && (($urandom % 10) < 6);
        out_ready_i = (($urandom % 10) < 7);
        if (out_valid_o && out_ready_i) begin
          chk(out_addr_o == exp_addr(s, oi) && !out_err_o, "R6 R2 delivery", out_addr_o, exp_addr(s, oi));
          oi++;
        end
        pending = pending + int'(bus_gnt_i) - int'(bus_rvalid_i);
        prev_req = bus_req_o; prev_gnt = bus_gnt_i; prev_addr = bus_addr_o;
      end
      idle();
      chk(oi == TOT, "R6 all delivered", 32'(oi), 32'(TOT));
      chk(ri == TOT, "R3 one line per buffer", 32'(ri), 32'(TOT));
      chk(pending == 0 && !bus_req_o, "R6 bus idle", 32'(pending), 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule